// File: doc/BRIEF.md
# Set-Associative Cache Tag Simulator

This block models only the tag side of a set-associative cache. It accepts one byte address per cycle, decides whether that address falls in a block the cache currently holds, and reports hit or miss one cycle later. No data is stored. A miss simply installs the new tag, so a sequence of addresses can be replayed to find its hit rate for a chosen geometry. Two running counters, one for accesses and one for hits, give that hit rate at the end of the sequence.

Block size, number of ways and total capacity in bytes are elaboration parameters, and the set count is derived from them. The eviction rule is picked at run time: least-recently-used or first-in-first-out. The select is sampled only when the cache is reset or cleared. A clear pulse empties every set and zeroes both counters, so one instance can replay many sequences in a row.

Top module: `cache_tag_sim`

## Requirements
- R1: The number of sets is CAPACITY / (WAYS * BLOCK_BYTES), and all three are powers of two. Address bits [log2(BLOCK_BYTES)-1:0] are the byte offset and are ignored. The next log2(sets) bits pick the set. The remaining upper bits form the tag. Accesses to one set never change the contents of another set.
- R2: An access hits only if some way of its set is valid and holds the same tag. After reset or clear, the first access to any block misses.
- R3: When req_valid is high and clear is low on a clock edge, rsp_valid is high for exactly the following cycle, and rsp_hit (1 = hit, 0 = miss) gives the result. rsp_hit is never high while rsp_valid is low.
- R4: A miss in a set that still has an invalid way fills the lowest-numbered invalid way and evicts nothing.
- R5: With LRU selected (lru_sel = 1), a miss in a full set replaces the way whose most recent hit or fill is oldest.
- R6: With FIFO selected (lru_sel = 0), a miss in a full set replaces the way that was filled earliest. Hits do not change this order.
- R7: lru_sel is sampled only in a cycle where rst or clear is high. A change at any other time does not alter the eviction rule until the next clear.
- R8: access_count rises by one for each accepted access. hit_count rises by one for each hit. Both saturate at all ones, and hit_count never exceeds access_count.
- R9: clear invalidates every way and zeroes both counters in the next cycle. A request presented in the same cycle as clear is dropped and produces no response.
- R10: With 16-byte blocks, 2 ways and 256 bytes, the byte addresses 0, 16, 24, 25, 1024, 255, 110, 305 on an empty cache hit only at positions 2 and 3 (counting from 0). With 32-byte blocks, positions 1, 2 and 3 hit and the rest miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples lru_sel |
| clear | input | 1 | Empties all sets, zeroes the counters and samples lru_sel |
| lru_sel | input | 1 | Eviction rule: 1 = LRU, 0 = FIFO |
| req_valid | input | 1 | An address is presented this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Result of the previous cycle's access is present |
| rsp_hit | output | 1 | 1 = hit, 0 = miss; meaningful when rsp_valid is high |
| access_count | output | CNT_W | Saturating count of accepted accesses |
| hit_count | output | CNT_W | Saturating count of hits |

## Verification
The hardest case to reach from the ports is the one that separates the two eviction rules. The set has to be full, an older way has to be hit, and then a third tag has to miss. Only the way chosen for eviction differs, and it shows only on a later access. The stimulus builds such sequences within one set and compares the later hit or miss. A second sequence changes lru_sel while the cache is running and shows that the old rule stays in force. A narrow-counter instance replays the address sequence from R10 long enough to reach saturation.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_LRU  = 1'b1
  } policy_e;
endpackage

// File: rtl/cts_lookup.sv
// Parallel tag compare across the ways of one set, plus lowest free way.
module cts_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 9,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]            valid_row,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_row,
  input  logic [TAG_W-1:0]           tag_in,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       has_free,
  output logic [WAY_W-1:0]           free_way
);
  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    has_free = 1'b0;
    free_way = '0;
    // descending scan so the lowest index wins
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_row[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
      if (valid_row[w] && (tag_row[w] == tag_in)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cts_victim.sv
// Victim choice: free way first, else oldest age (LRU) or fill pointer (FIFO).
module cts_victim
  import cts_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  policy_e                    policy,
  input  logic [WAYS-1:0][WAY_W-1:0] age_row,
  input  logic [WAY_W-1:0]           fifo_ptr,
  input  logic                       has_free,
  input  logic [WAY_W-1:0]           free_way,
  output logic [WAY_W-1:0]           victim
);
  always_comb begin
    victim = fifo_ptr;
    if (has_free) begin
      victim = free_way;
    end else if (policy == POL_LRU) begin
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (age_row[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cts_sat_counter.sv
module cts_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (clr)                       count <= '0;
    else if (inc && (count != '1)) count <= count + 1'b1;
  end
endmodule

// File: rtl/cache_tag_sim.sv
module cache_tag_sim
  import cts_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 2,
  parameter int CAPACITY    = 256,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              lru_sel,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  hit_count
);
  localparam int SETS     = CAPACITY / (WAYS * BLOCK_BYTES);
  localparam int OFF_W    = $clog2(BLOCK_BYTES);
  localparam int IDX_BITS = $clog2(SETS);
  localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_BITS;

  // replacement state and tags, one row per set
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][WAY_W-1:0]  age_q   [SETS];
  logic [WAY_W-1:0]            ptr_q   [SETS];
  policy_e                     policy_q;

  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic             hit, has_free;
  logic [WAY_W-1:0] hit_way, free_way, victim, touch, ptr_next;

  generate
    if (IDX_BITS > 0) begin : g_idx
      assign set_idx = req_addr[OFF_W +: IDX_BITS];
    end else begin : g_noidx
      assign set_idx = '0;
    end
  endgenerate
  assign tag_in = req_addr[ADDR_W-1 -: TAG_W];

  cts_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
    .valid_row (valid_q[set_idx]),
    .tag_row   (tag_q[set_idx]),
    .tag_in    (tag_in),
    .hit       (hit),
    .hit_way   (hit_way),
    .has_free  (has_free),
    .free_way  (free_way)
  );

  cts_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .policy   (policy_q),
    .age_row  (age_q[set_idx]),
    .fifo_ptr (ptr_q[set_idx]),
    .has_free (has_free),
    .free_way (free_way),
    .victim   (victim)
  );

  assign touch    = hit ? hit_way : victim;
  assign ptr_next = (victim == WAY_W'(WAYS - 1)) ? '0 : victim + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      policy_q <= policy_e'(lru_sel);
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        ptr_q[s]   <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (req_valid) begin
      if (!hit) begin
        valid_q[set_idx][victim] <= 1'b1;
        tag_q[set_idx][victim]   <= tag_in;
        ptr_q[set_idx]           <= ptr_next;
      end
      // recency: touched way becomes youngest, younger ones age by one
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch)
          age_q[set_idx][w] <= '0;
        else if (age_q[set_idx][w] < age_q[set_idx][touch])
          age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit;
    end
  end

  cts_sat_counter #(.W(CNT_W)) u_acc_cnt (
    .clk   (clk),
    .clr   (rst || clear),
    .inc   (req_valid),
    .count (access_count)
  );

  cts_sat_counter #(.W(CNT_W)) u_hit_cnt (
    .clk   (clk),
    .clr   (rst || clear),
    .inc   (req_valid && hit),
    .count (hit_count)
  );
endmodule

// File: rtl/cts_checker.sv
module cts_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             clear,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] access_count,
  input logic [CNT_W-1:0] hit_count
);
  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid == $past(req_valid && !clear)));

  a_r3_hit_qualified: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  a_r8_hits_bounded: assert property (@(posedge clk) disable iff (rst)
    hit_count <= access_count);

  a_r8_access_step: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !clear && (access_count != '1)) |=>
      (access_count == $past(access_count) + 1'b1));

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    ((access_count == '1) && !clear) |=> (access_count == '1));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear |=> ((access_count == '0) && (hit_count == '0) && !rsp_valid));
endmodule

bind cache_tag_sim cts_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clear        (clear),
  .req_valid    (req_valid),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .access_count (access_count),
  .hit_count    (hit_count)
);

// File: tb/cache_tag_sim_tb.sv
`timescale 1ns/1ps
module cache_tag_sim_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear = 1'b0;
  logic        lru_sel = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_valid32 = 1'b0;
  logic [15:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_valid32, rsp_hit32;
  logic [31:0] acc_cnt, hit_cnt;
  logic [2:0]  acc_cnt32, hit_cnt32;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  bit    q_hit[$];
  string q_req[$];
  bit    q32_hit[$];
  string q32_req[$];

  always #2.5 clk = ~clk;

  cache_tag_sim #(.ADDR_W(16), .BLOCK_BYTES(16), .WAYS(2), .CAPACITY(256), .CNT_W(32)) u_dut (
    .clk(clk), .rst(rst), .clear(clear), .lru_sel(lru_sel),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .access_count(acc_cnt), .hit_count(hit_cnt));

  cache_tag_sim #(.ADDR_W(16), .BLOCK_BYTES(32), .WAYS(2), .CAPACITY(256), .CNT_W(3)) u_dut32 (
    .clk(clk), .rst(rst), .clear(clear), .lru_sel(lru_sel),
    .req_valid(req_valid32), .req_addr(req_addr),
    .rsp_valid(rsp_valid32), .rsp_hit(rsp_hit32),
    .access_count(acc_cnt32), .hit_count(hit_cnt32));

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (q_hit.size() == 0) chk(1'b0, "R9", "unexpected response", 1, 0);
        else begin
          automatic bit e = q_hit.pop_front();
          automatic string r = q_req.pop_front();
          chk(rsp_hit == e, r, "rsp_hit", int'(rsp_hit), int'(e));
        end
      end
      if (rsp_valid32) begin
        if (q32_hit.size() == 0) chk(1'b0, "R3", "unexpected response (32B)", 1, 0);
        else begin
          automatic bit e = q32_hit.pop_front();
          automatic string r = q32_req.pop_front();
          chk(rsp_hit32 == e, r, "rsp_hit (32B)", int'(rsp_hit32), int'(e));
        end
      end
    end
  end

  task automatic access(input logic [15:0] a, input bit exp_hit, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_valid32 = 1'b0;
    req_addr = a;
    q_hit.push_back(exp_hit);
    q_req.push_back(req);
  endtask

  task automatic access_both(input logic [15:0] a, input bit h16, input bit h32);
    @(negedge clk);
    req_valid = 1'b1;
    req_valid32 = 1'b1;
    req_addr = a;
    q_hit.push_back(h16);
    q_req.push_back("R10");
    q32_hit.push_back(h32);
    q32_req.push_back("R10");
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_valid32 = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear(input bit lru);
    @(negedge clk);
    req_valid = 1'b0;
    req_valid32 = 1'b0;
    clear = 1'b1;
    lru_sel = lru;
    @(negedge clk);
    clear = 1'b0;
  endtask

  // set 0 addresses for the 16-byte instance: tag = addr[15:7]
  localparam logic [15:0] A = 16'd0, B = 16'd128, C = 16'd256, D = 16'd16;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R3", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(acc_cnt == 0, "R8", "access_count after reset", int'(acc_cnt), 0);
    chk(hit_cnt == 0, "R8", "hit_count after reset", int'(hit_cnt), 0);

    // R10 / R1 / R2: reference address sequence on both geometries
    access_both(16'd0,    1'b0, 1'b0);
    access_both(16'd16,   1'b0, 1'b1);
    access_both(16'd24,   1'b1, 1'b1);
    access_both(16'd25,   1'b1, 1'b1);
    access_both(16'd1024, 1'b0, 1'b0);
    access_both(16'd255,  1'b0, 1'b0);
    access_both(16'd110,  1'b0, 1'b0);
    access_both(16'd305,  1'b0, 1'b0);
    idle();
    chk(acc_cnt == 8, "R8", "access_count after sequence", int'(acc_cnt), 8);
    chk(hit_cnt == 2, "R8", "hit_count after sequence", int'(hit_cnt), 2);
    chk(acc_cnt32 == 3'd7, "R8", "access_count saturates", int'(acc_cnt32), 7);
    chk(hit_cnt32 == 3'd3, "R8", "hit_count 32B", int'(hit_cnt32), 3);

    // R4 / R1: free ways fill without eviction; other set untouched
    do_clear(1'b1);
    chk(acc_cnt == 0 && hit_cnt == 0, "R9", "counters after clear", int'(acc_cnt), 0);
    access(A, 1'b0, "R2");
    access(B, 1'b0, "R4");
    access(A, 1'b1, "R4");
    access(B, 1'b1, "R4");
    access(D, 1'b0, "R1");
    access(A, 1'b1, "R1");
    access(B, 1'b1, "R1");
    idle();
    chk(acc_cnt == 7, "R8", "access_count", int'(acc_cnt), 7);
    chk(hit_cnt == 4, "R8", "hit_count", int'(hit_cnt), 4);

    // R5: LRU
    do_clear(1'b1);
    access(A, 1'b0, "R5");
    access(B, 1'b0, "R5");
    access(A, 1'b1, "R5");
    access(C, 1'b0, "R5");   // evicts B
    access(A, 1'b1, "R5");
    access(B, 1'b0, "R5");   // evicts C
    access(C, 1'b0, "R5");   // evicts A
    access(B, 1'b1, "R5");
    access(A, 1'b0, "R5");
    idle();

    // R6: FIFO
    do_clear(1'b0);
    access(A, 1'b0, "R6");
    access(B, 1'b0, "R6");
    access(A, 1'b1, "R6");
    access(C, 1'b0, "R6");   // evicts A (first filled)
    access(A, 1'b0, "R6");   // evicts B
    access(B, 1'b0, "R6");   // evicts C
    access(A, 1'b1, "R6");
    idle();

    // R7: select change without clear keeps LRU
    do_clear(1'b1);
    @(negedge clk);
    lru_sel = 1'b0;
    access(A, 1'b0, "R7");
    access(B, 1'b0, "R7");
    access(A, 1'b1, "R7");
    access(C, 1'b0, "R7");   // LRU evicts B
    access(A, 1'b1, "R7");   // would miss under FIFO
    idle();

    // R9: clear with a concurrent request drops it
    access(A, 1'b1, "R9");
    @(negedge clk);
    clear = 1'b1;
    req_valid = 1'b1;
    req_addr = A;
    @(negedge clk);
    clear = 1'b0;
    req_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R9", "no response to request during clear", int'(rsp_valid), 0);
    chk(acc_cnt == 0, "R9", "access_count zero after clear", int'(acc_cnt), 0);
    chk(hit_cnt == 0, "R9", "hit_count zero after clear", int'(hit_cnt), 0);
    access(A, 1'b0, "R9");
    idle();
    chk(acc_cnt == 1, "R9", "access_count after clear+access", int'(acc_cnt), 1);
    chk(hit_cnt == 0, "R9", "hit_count after clear+miss", int'(hit_cnt), 0);

    @(negedge clk);
    chk(q_hit.size() == 0, "R3", "pending responses", q_hit.size(), 0);
    chk(q32_hit.size() == 0, "R3", "pending responses (32B)", q32_hit.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule